// File: doc/BRIEF.md
# GPIO Expander Register Front End

This block is the register side of an eight-pin GPIO expander that is reached through a byte-oriented serial target interface. The bus side of the interface hands the block one byte per beat. Each beat carries a start flag that opens a combined transaction, an end flag that closes it, and a read/write flag. The block keeps the pin output levels, the pin directions, the interrupt mask and four trigger-configuration bytes. It samples the pin levels through a synchronizer. It drives the pad output-enable and the pad output level.

A register access takes two beats. A write beat carrying the start flag sets the register pointer. A later write beat in the same transaction stores its byte at the pointer, and a read beat returns the register at the pointer one clock later. The pointer keeps its value between transactions and does not advance.

A separate event detector owns the interrupt status byte. This block reads that byte from the detector and hands the detector the mask and trigger settings. When the status byte is read, the block sends a one-cycle pulse so the detector can clear its status.

Top module: `gpx_regport`

## Requirements
- R1: After reset the direction byte is 0xFF (all pins inputs) and the output-level, mask and trigger bytes are 0x00, so padOe is 0x00.
- R2: A write beat that has beatStart set loads beatData into the register pointer and changes no register. The pointer is kept across transactions.
- R3: A read beat makes rspValid high for exactly one cycle in the cycle after the beat, with rspData holding the register at the pointer. A read beat does not change the pointer.
- R4: A write beat without beatStart, inside a transaction whose start beat was a write, stores beatData at the pointer. The writable addresses are 0x00 (output level), 0x02 (direction), 0x03 (mask) and 0x05 to 0x08 (trigger bytes 0 to 3). A write beat that arrives after the end beat and before a new start beat is ignored.
- R5: For each pin i, padOe[i] is 1 exactly when direction bit i is 0 (a 1 means input), and padOut[i] equals output-level bit i. Both outputs follow a write in the next cycle.
- R6: The pin levels pass through two synchronizer flops and then an input register. A read of 0x01 returns the level that padIn had at the clock edge three edges before the read beat is sampled.
- R7: Writes to 0x01, to 0x04 and to any address of 0x09 or above change nothing. Reads of addresses 0x09 and above return 0x00.
- R8: A read of 0x04 returns irqStatusIn as sampled at the read beat. It also raises statusRdPulse for one cycle together with rspValid. Reads of other addresses leave statusRdPulse low.
- R9: Reads of 0x00 and 0x02 return the stored output-level and direction bytes.
- R10: irqMask carries the mask byte, and trigCfg carries trigger byte k on bits 8k+7 to 8k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| beatValid | input | 1 | A byte beat is present this cycle |
| beatStart | input | 1 | Beat opens a combined transaction |
| beatEnd | input | 1 | Beat closes the transaction |
| beatRead | input | 1 | 1 = read beat, 0 = write beat |
| beatData | input | 8 | Written byte (pointer or data) |
| rspValid | output | 1 | Read response present |
| rspData | output | 8 | Read response byte |
| padIn | input | 8 | Raw pin levels |
| padOe | output | 8 | Pad output enable per pin |
| padOut | output | 8 | Pad output level per pin |
| irqStatusIn | input | 8 | Status byte from the event detector |
| irqMask | output | 8 | Interrupt mask to the detector |
| trigCfg | output | 32 | Four trigger bytes to the detector |
| statusRdPulse | output | 1 | One-cycle pulse when the status byte is read |

## Verification
A wrong direction or output-level byte appears on padOe or padOut in the cycle after the write that caused it. A wrong mask or trigger byte appears on irqMask or trigCfg in that same cycle. A corrupted pointer, or a transaction that is wrongly still open, only shows at the ports when a later access happens: a write that should have been ignored changes a pad output in the next cycle, and a misdirected read returns a wrong byte one cycle after the read beat. A reference model compares every port on every clock, so each of these faults is caught within one cycle of its first effect at the ports.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = BYTE_W;
  localparam int ADDR_OUT  = 0;
  localparam int ADDR_IN   = 1;
  localparam int ADDR_DIR  = 2;
  localparam int ADDR_MASK = 3;
  localparam int ADDR_STAT = 4;
  localparam int TRIG_BASE = 5;

  typedef struct packed {
    logic              regWr;
    logic              regRd;
    logic [ADDR_W-1:0] addr;
    logic [BYTE_W-1:0] wrData;
  } strobe_t;
endpackage

// File: rtl/gpx_ctrl.sv
module gpx_ctrl
  import gpx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              beatValid,
  input  logic              beatStart,
  input  logic              beatEnd,
  input  logic              beatRead,
  input  logic [BYTE_W-1:0] beatData,
  output strobe_t           strobe,
  output logic              statusRdPulse
);
  logic [ADDR_W-1:0] ptrQ;
  logic              openQ;
  logic              isWr;
  logic              isRd;

  assign isWr = beatValid & ~beatRead;
  assign isRd = beatValid & beatRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrQ          <= '0;
      openQ         <= 1'b0;
      statusRdPulse <= 1'b0;
    end else begin
      statusRdPulse <= isRd && (ptrQ == ADDR_W'(ADDR_STAT));
      if (isWr && beatStart) begin
        ptrQ  <= beatData;
        openQ <= ~beatEnd;
      end else if (isRd && beatStart) begin
        openQ <= 1'b0;
      end else if (beatValid && beatEnd) begin
        openQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strobe.regWr  = isWr & ~beatStart & openQ;
    strobe.regRd  = isRd;
    strobe.addr   = ptrQ;
    strobe.wrData = beatData;
  end

  p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    isRd |=> (ptrQ == $past(ptrQ)));
  p_closed_after_end_r4: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && beatEnd) |=> !strobe.regWr);
  p_pulse_from_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    statusRdPulse |-> $past(strobe.regRd));
endmodule

// File: rtl/gpx_datapath.sv
module gpx_datapath
  import gpx_pkg::*;
#(
  parameter int TRIG_REGS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strobe,
  input  logic [BYTE_W-1:0]           padIn,
  input  logic [BYTE_W-1:0]           irqStatusIn,
  output logic [BYTE_W-1:0]           padOe,
  output logic [BYTE_W-1:0]           padOut,
  output logic [BYTE_W-1:0]           irqMask,
  output logic [TRIG_REGS*BYTE_W-1:0] trigCfg,
  output logic                        rspValid,
  output logic [BYTE_W-1:0]           rspData
);
  localparam int TIDX_W   = (TRIG_REGS > 1) ? $clog2(TRIG_REGS) : 1;
  localparam int TRIG_END = TRIG_BASE + TRIG_REGS;

  logic [BYTE_W-1:0] outQ, dirQ, maskQ, inQ;
  logic [BYTE_W-1:0] trigQ [TRIG_REGS];
  logic [BYTE_W-1:0] syncQ [SYNC_STAGES];
  logic [BYTE_W-1:0] rdMux;
  logic [ADDR_W-1:0] trigOff;

  // pin synchronizer chain
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       syncQ[s] <= '0;
      else if (s == 0) syncQ[s] <= padIn;
      else             syncQ[s] <= syncQ[(s > 0) ? s-1 : 0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ  <= '0;
      dirQ  <= '1;
      maskQ <= '0;
      inQ   <= '0;
    end else begin
      inQ <= syncQ[SYNC_STAGES-1];
      if (strobe.regWr) begin
        case (strobe.addr)
          ADDR_W'(ADDR_OUT):  outQ  <= strobe.wrData;
          ADDR_W'(ADDR_DIR):  dirQ  <= strobe.wrData;
          ADDR_W'(ADDR_MASK): maskQ <= strobe.wrData;
          default: ;
        endcase
      end
    end
  end

  for (genvar k = 0; k < TRIG_REGS; k++) begin : g_trig
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        trigQ[k] <= '0;
      else if (strobe.regWr && strobe.addr == ADDR_W'(TRIG_BASE + k))
        trigQ[k] <= strobe.wrData;
    end
    assign trigCfg[k*BYTE_W +: BYTE_W] = trigQ[k];
  end

  assign trigOff = strobe.addr - ADDR_W'(TRIG_BASE);

  always_comb begin
    rdMux = '0;
    case (strobe.addr)
      ADDR_W'(ADDR_OUT):  rdMux = outQ;
      ADDR_W'(ADDR_IN):   rdMux = inQ;
      ADDR_W'(ADDR_DIR):  rdMux = dirQ;
      ADDR_W'(ADDR_MASK): rdMux = maskQ;
      ADDR_W'(ADDR_STAT): rdMux = irqStatusIn;
      default: begin
        if (strobe.addr >= ADDR_W'(TRIG_BASE) && strobe.addr < ADDR_W'(TRIG_END))
          rdMux = trigQ[trigOff[TIDX_W-1:0]];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.regRd;
      if (strobe.regRd) rspData <= rdMux;
    end
  end

  assign padOe   = ~dirQ;
  assign padOut  = outQ;
  assign irqMask = maskQ;

  p_dir_follow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.regWr && strobe.addr == ADDR_W'(ADDR_DIR)) |=> (padOe == ~$past(strobe.wrData)));
  p_out_follow_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.regWr && strobe.addr == ADDR_W'(ADDR_OUT)) |=> (padOut == $past(strobe.wrData)));
  p_ro_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.regWr && (strobe.addr == ADDR_W'(ADDR_IN) || strobe.addr == ADDR_W'(ADDR_STAT)))
      |=> ($stable(padOe) && $stable(padOut) && $stable(irqMask) && $stable(trigCfg)));
  p_status_read_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.regRd && strobe.addr == ADDR_W'(ADDR_STAT)) |=> (rspData == $past(irqStatusIn)));
endmodule

// File: rtl/gpx_regport.sv
module gpx_regport
  import gpx_pkg::*;
#(
  parameter int TRIG_REGS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        beatValid,
  input  logic                        beatStart,
  input  logic                        beatEnd,
  input  logic                        beatRead,
  input  logic [BYTE_W-1:0]           beatData,
  output logic                        rspValid,
  output logic [BYTE_W-1:0]           rspData,
  input  logic [BYTE_W-1:0]           padIn,
  output logic [BYTE_W-1:0]           padOe,
  output logic [BYTE_W-1:0]           padOut,
  input  logic [BYTE_W-1:0]           irqStatusIn,
  output logic [BYTE_W-1:0]           irqMask,
  output logic [TRIG_REGS*BYTE_W-1:0] trigCfg,
  output logic                        statusRdPulse
);
  strobe_t strobe;

  gpx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .beatValid(beatValid), .beatStart(beatStart),
    .beatEnd(beatEnd), .beatRead(beatRead), .beatData(beatData),
    .strobe(strobe), .statusRdPulse(statusRdPulse)
  );

  gpx_datapath #(.TRIG_REGS(TRIG_REGS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .padIn(padIn),
    .irqStatusIn(irqStatusIn), .padOe(padOe), .padOut(padOut),
    .irqMask(irqMask), .trigCfg(trigCfg), .rspValid(rspValid), .rspData(rspData)
  );

  p_pulse_with_rsp_r8: assert property (@(posedge clk) disable iff (!rstN)
    statusRdPulse |-> rspValid);
  p_rsp_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !$past(strobe.regRd)) |-> 1'b0);
endmodule

// File: tb/gpx_regport_tb.sv
module gpx_regport_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, beatValid, beatStart, beatEnd, beatRead;
  logic [7:0] beatData, rspData, padIn, padOe, padOut, irqStatusIn, irqMask;
  logic [31:0] trigCfg;
  logic rspValid, statusRdPulse;

  gpx_regport u_dut (
    .clk(clk), .rstN(rstN), .beatValid(beatValid), .beatStart(beatStart),
    .beatEnd(beatEnd), .beatRead(beatRead), .beatData(beatData),
    .rspValid(rspValid), .rspData(rspData), .padIn(padIn), .padOe(padOe),
    .padOut(padOut), .irqStatusIn(irqStatusIn), .irqMask(irqMask),
    .trigCfg(trigCfg), .statusRdPulse(statusRdPulse)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  byte unsigned mOut, mDir, mMask, mPtr, mRspD;
  byte unsigned mTrig [4];
  byte unsigned padHist [$];
  bit mOpen, mRspV, mPulse;

  function automatic byte unsigned inView();
    return (padHist.size() >= 3) ? padHist[padHist.size()-3] : 8'h00;
  endfunction

  function automatic byte unsigned modelRead(byte unsigned a);
    case (a)
      0: return mOut;
      1: return inView();
      2: return mDir;
      3: return mMask;
      4: return irqStatusIn;
      5, 6, 7, 8: return mTrig[a-5];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    #2;
    if (!rstN) begin
      mOut = 0; mDir = 8'hFF; mMask = 0; mPtr = 0; mOpen = 0;
      mRspV = 0; mRspD = 0; mPulse = 0;
      foreach (mTrig[k]) mTrig[k] = 0;
      padHist.delete();
    end else begin
      mRspV  = beatValid && beatRead;
      mPulse = mRspV && (mPtr == 4);
      if (mRspV) mRspD = modelRead(mPtr);
      if (beatValid && !beatRead && !beatStart && mOpen) begin
        case (mPtr)
          0: mOut = beatData;
          2: mDir = beatData;
          3: mMask = beatData;
          5, 6, 7, 8: mTrig[mPtr-5] = beatData;
          default: ;
        endcase
      end
      if (beatValid && !beatRead && beatStart) begin
        mPtr = beatData; mOpen = !beatEnd;
      end else if (beatValid && beatStart) mOpen = 0;
      else if (beatValid && beatEnd) mOpen = 0;
      padHist.push_back(padIn);
    end
    if (!done) begin
      chk(padOe == ~mDir, "R5", "padOe", padOe, 8'(~mDir));
      chk(padOut == mOut, "R5", "padOut", padOut, mOut);
      chk(irqMask == mMask, "R10", "irqMask", irqMask, mMask);
      chk(trigCfg == {mTrig[3], mTrig[2], mTrig[1], mTrig[0]}, "R10", "trigCfg",
          trigCfg, {mTrig[3], mTrig[2], mTrig[1], mTrig[0]});
      chk(rspValid == mRspV, "R3", "rspValid", rspValid, mRspV);
      if (mRspV) chk(rspData == mRspD, "R3", "rspData", rspData, mRspD);
      chk(statusRdPulse == mPulse, "R8", "statusRdPulse", statusRdPulse, mPulse);
    end
  end

  task automatic sendBeat(bit s, bit e, bit r, byte unsigned d);
    @(negedge clk);
    beatValid = 1; beatStart = s; beatEnd = e; beatRead = r; beatData = d;
    @(negedge clk);
    beatValid = 0; beatStart = 0; beatEnd = 0; beatRead = 0;
  endtask

  task automatic writeReg(byte unsigned a, byte unsigned d);
    sendBeat(1, 0, 0, a);
    sendBeat(0, 1, 0, d);
  endtask

  task automatic readReg(byte unsigned a, byte unsigned exp, string req);
    sendBeat(1, 0, 0, a);
    sendBeat(0, 1, 1, 0);
    chk(rspValid == 1'b1, req, "read valid", rspValid, 1);
    chk(rspData == exp, req, "read data", rspData, exp);
  endtask

  initial begin
    rstN = 0; beatValid = 0; beatStart = 0; beatEnd = 0; beatRead = 0;
    beatData = 0; padIn = 8'h00; irqStatusIn = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(padOe == 8'h00, "R1", "reset padOe", padOe, 0);
    chk(irqMask == 8'h00 && trigCfg == 0, "R1", "reset mask/trig", irqMask, 0);
    rstN = 1;
    readReg(2, 8'hFF, "R1");
    // R4 R5 R9 output and direction
    writeReg(0, 8'hA5);
    writeReg(2, 8'h0F);
    chk(padOe == 8'hF0, "R5", "padOe after dir", padOe, 8'hF0);
    chk(padOut == 8'hA5, "R4", "padOut after write", padOut, 8'hA5);
    readReg(0, 8'hA5, "R9");
    readReg(2, 8'h0F, "R9");
    // R10 mask and trigger bytes
    writeReg(3, 8'h3C);
    for (int k = 0; k < 4; k++) writeReg(byte'(5 + k), byte'(8'h11 * (k + 1)));
    chk(trigCfg == 32'h44332211, "R10", "trigCfg", trigCfg, 32'h44332211);
    chk(irqMask == 8'h3C, "R10", "irqMask", irqMask, 8'h3C);
    readReg(7, 8'h33, "R10");
    // R6 synchronized input
    padIn = 8'h5A;
    repeat (4) @(negedge clk);
    readReg(1, 8'h5A, "R6");
    // R7 ignored writes and unmapped reads
    writeReg(1, 8'hFF);
    writeReg(4, 8'hFF);
    writeReg(8'h0C, 8'hFF);
    chk(padOut == 8'hA5 && padOe == 8'hF0, "R7", "pads after ignored writes", padOut, 8'hA5);
    readReg(8'h0C, 8'h00, "R7");
    readReg(8'h09, 8'h00, "R7");
    // R8 status read and pulse
    irqStatusIn = 8'h81;
    sendBeat(1, 0, 0, 4);
    sendBeat(0, 1, 1, 0);
    chk(statusRdPulse == 1'b1, "R8", "pulse", statusRdPulse, 1);
    chk(rspData == 8'h81, "R8", "status data", rspData, 8'h81);
    // R4 stray write after end is ignored
    writeReg(0, 8'h3C);
    sendBeat(0, 0, 0, 8'hFF);
    chk(padOut == 8'h3C, "R4", "stray write", padOut, 8'h3C);
    // R2 pointer only, then pointer kept for a later read
    sendBeat(1, 1, 0, 2);
    chk(padOe == 8'hF0, "R2", "pointer load no write", padOe, 8'hF0);
    sendBeat(1, 1, 1, 0);
    chk(rspData == 8'h0F, "R2", "kept pointer read", rspData, 8'h0F);
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule